// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block stores an incoming byte stream into memory buffers that are described by a small ring of receive descriptors. It keeps a local copy of the current descriptor. When the first byte of a new buffer arrives, it checks the empty flag on that copy and does not read the descriptor again at that moment. If the descriptor is free, the block writes bytes one after another from the buffer pointer. The buffer closes on end-of-frame, on an errored byte, or when the buffer reaches its fixed capacity. At close, the block writes back the status and the byte count, and moves to the next descriptor.

If the copy shows a descriptor that software has not yet returned, the block raises a one-cycle busy error and drops the byte. It then stays on that descriptor. The copy is refreshed from the descriptor table every `REFRESH` cycles. Each refresh that still finds the descriptor in use raises the busy error again, and the first refresh that finds it free ends the stall.

The descriptor table is reached through an asynchronous read port and a synchronous write port. Buffer memory is reached through a write-only byte port.

Top module: `rx_ring_mgr`

## Requirements
- R1: After `enable` rises, the copy of descriptor 0 is loaded on the next clock edge, and the first stored byte goes to descriptor 0's pointer.
- R2: Each accepted byte without an error flag is written in the same cycle (`buf_we`=1) to address pointer + n, where n is the number of bytes already stored in that buffer.
- R3: A buffer closes on the byte that carries `in_eof` (that byte is stored) or on the byte that makes the count reach `MAX_BUF`. The write-back length field holds the stored count. The last-in-frame bit equals `in_eof` of the closing byte.
- R4: A byte that carries `in_err` is not stored. It closes the buffer with the error bit set and the length equal to the bytes stored before it.
- R5: After a close, the next descriptor is index 0 if the closed descriptor had its wrap bit set or was the last table entry. Otherwise it is index + 1.
- R6: The write-back keeps pointer, wrap and continuous fields. It writes the empty bit as 0, or as 1 when the continuous bit is set. Word layout with default parameters: pointer [15:0], length [19:16], error 20, last 21, continuous 22, wrap 23, empty 24.
- R7: A byte that would start a buffer while the held copy has empty=0 is dropped. It raises `busy_err` for exactly that cycle and causes no buffer or descriptor write.
- R8: While stalled, further bytes are dropped with no busy error. `busy_err` pulses once at each refresh (every `REFRESH` cycles) that still reads empty=0.
- R9: The first refresh that reads empty=1 ends the stall without a busy error. The next byte is then stored at that same descriptor's pointer.
- R10: While `enable` is low, no buffer write, descriptor write or busy error occurs. A partly filled buffer is abandoned, and the walker restarts at descriptor 0 on re-enable.
- R11: After reset, `buf_we`, `desc_wr_en` and `busy_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receive enable |
| in_valid | input | 1 | Byte present this cycle |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | Byte ends the frame |
| in_err | input | 1 | Byte carries an error |
| desc_rd_idx | output | IDX_W | Descriptor read index |
| desc_rd_data | input | DESC_W | Descriptor word at `desc_rd_idx` (same cycle) |
| desc_wr_en | output | 1 | Descriptor write-back strobe |
| desc_wr_idx | output | IDX_W | Descriptor write-back index |
| desc_wr_data | output | DESC_W | Descriptor write-back word |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_data | output | 8 | Buffer byte |
| busy_err | output | 1 | Busy error pulse |

## Verification
A wrong descriptor index or byte count shows at the ports at once. The next buffer write goes to the wrong address, or the next write-back carries the wrong index or length, in the same cycle as the byte that exposes it. A wrong stall flag or a stale copy shows as a missing or extra `busy_err` pulse. It can also show as a byte stored while the descriptor is in use. It becomes visible within one refresh interval after the walker reaches a descriptor that software has not returned. A wrong wrap decision shows when the walker next closes a buffer, because the following byte lands at the wrong pointer.

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int NUM_DESC = 4,
  parameter int ADDR_W   = 16,
  parameter int MAX_BUF  = 8,
  parameter int REFRESH  = 16,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int LEN_W   = $clog2(MAX_BUF + 1),
  localparam int DESC_W  = ADDR_W + LEN_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_eof,
  input  logic              in_err,
  output logic [IDX_W-1:0]  desc_rd_idx,
  input  logic [DESC_W-1:0] desc_rd_data,
  output logic              desc_wr_en,
  output logic [IDX_W-1:0]  desc_wr_idx,
  output logic [DESC_W-1:0] desc_wr_data,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_data,
  output logic              busy_err
);
  localparam int P_LEN   = ADDR_W;
  localparam int P_ERR   = ADDR_W + LEN_W;
  localparam int P_LAST  = P_ERR + 1;
  localparam int P_CONT  = P_ERR + 2;
  localparam int P_WRAP  = P_ERR + 3;
  localparam int P_EMPTY = P_ERR + 4;
  localparam int RC_W    = $clog2(REFRESH) + 1;

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_FILL} st_t;

  st_t              st;
  logic [IDX_W-1:0] cur;
  logic [DESC_W-1:0] copy;
  logic [LEN_W-1:0] cnt;
  logic [RC_W-1:0]  rcnt;
  logic             stalled;

  logic live, in_wait, in_fill, start, refuse, take, store, close, hit, refresh;
  logic [LEN_W-1:0] base, cnt_nx;
  logic [IDX_W-1:0] nxt;

  assign live    = enable && (st != S_OFF);
  assign in_wait = live && (st == S_WAIT);
  assign in_fill = live && (st == S_FILL);
  assign start   = in_wait && in_valid && !stalled && copy[P_EMPTY];
  assign refuse  = in_wait && in_valid && !stalled && !copy[P_EMPTY];
  assign take    = start || (in_fill && in_valid);
  assign store   = take && !in_err;
  assign base    = start ? '0 : cnt;
  assign cnt_nx  = base + LEN_W'(store);
  assign close   = take && (in_err || in_eof || cnt_nx == LEN_W'(MAX_BUF));
  assign hit     = in_wait && (rcnt == RC_W'(REFRESH - 1));
  assign refresh = hit && !start;
  assign nxt     = (copy[P_WRAP] || cur == IDX_W'(NUM_DESC - 1)) ? '0 : cur + 1'b1;

  assign busy_err     = refuse || (refresh && stalled && !desc_rd_data[P_EMPTY]);
  assign desc_rd_idx  = close ? nxt : cur;
  assign desc_wr_en   = close;
  assign desc_wr_idx  = cur;
  assign desc_wr_data = {copy[P_CONT], copy[P_WRAP], copy[P_CONT], in_eof, in_err,
                         cnt_nx, copy[ADDR_W-1:0]};
  assign buf_we       = store;
  assign buf_addr     = copy[ADDR_W-1:0] + ADDR_W'(base);
  assign buf_data     = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      st      <= S_OFF;
      cur     <= '0;
      cnt     <= '0;
      rcnt    <= '0;
      stalled <= 1'b0;
      if (!rst_n) copy <= '0;
    end else if (st == S_OFF) begin
      copy <= desc_rd_data;
      st   <= S_WAIT;
      rcnt <= '0;
    end else begin
      rcnt <= (hit || st == S_FILL) ? '0 : rcnt + 1'b1;
      if (close) begin
        cur     <= nxt;
        copy    <= (nxt == cur) ? desc_wr_data : desc_rd_data;
        cnt     <= '0;
        st      <= S_WAIT;
        rcnt    <= '0;
      end else if (take) begin
        cnt <= cnt_nx;
        st  <= S_FILL;
      end
      if (refuse) stalled <= 1'b1;
      if (refresh) begin
        copy <= desc_rd_data;
        if (stalled && desc_rd_data[P_EMPTY]) stalled <= 1'b0;
      end
    end
  end

  // R2
  addr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we && $past(buf_we) && !$past(desc_wr_en) |-> buf_addr == $past(buf_addr) + 1'b1);
  // R3
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> desc_wr_data[P_ERR-1:P_LEN] <= LEN_W'(MAX_BUF));
  // R3
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < LEN_W'(MAX_BUF));
  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> !buf_we && !desc_wr_en);
  // R8
  stall_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !buf_we && !desc_wr_en);
  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !buf_we && !desc_wr_en && !busy_err);
  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en && desc_wr_data[P_WRAP] |=> cur == '0 || !enable);
endmodule

// File: tb/rx_ring_mgr_test.sv
module rx_ring_mgr_test;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4, AW = 16, MB = 8, RF = 16;
  localparam int DW = AW + 4 + 5;

  logic clk = 0, rst_n = 0, enable = 0, in_valid = 0, in_eof = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic [1:0] rd_idx, wr_idx;
  logic [DW-1:0] rd_data, wr_data;
  logic wr_en, buf_we, busy;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_data;
  logic [DW-1:0] ram [ND];
  logic [AW-1:0] rptr [ND];
  logic rwrap [ND];
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_data = ram[rd_idx];
  always @(posedge clk) if (wr_en) ram[wr_idx] <= wr_data;
  always @(posedge clk) cyc <= cyc + 1;

  rx_ring_mgr #(.NUM_DESC(ND), .ADDR_W(AW), .MAX_BUF(MB), .REFRESH(RF)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid), .in_data(in_data),
    .in_eof(in_eof), .in_err(in_err), .desc_rd_idx(rd_idx), .desc_rd_data(rd_data),
    .desc_wr_en(wr_en), .desc_wr_idx(wr_idx), .desc_wr_data(wr_data),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .busy_err(busy));

  function automatic logic [DW-1:0] mk(logic e, logic w, logic c, logic l, logic r,
                                       int len, logic [AW-1:0] p);
    return {e, w, c, l, r, 4'(len), p};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input bit v, input logic [7:0] d, input bit e, input bit r);
    @(negedge clk);
    in_valid = v; in_data = d; in_eof = e; in_err = r;
    #1;
  endtask

  task automatic setup(input bit cont, input logic [AW-1:0] b);
    for (int i = 0; i < ND; i++) begin
      rptr[i] = b + AW'(i * 'h40);
      rwrap[i] = (i == 2);
      ram[i] = mk(1'b1, rwrap[i], cont, 1'b0, 1'b0, 0, rptr[i]);
    end
  endtask

  initial begin
    int m_idx, m_cnt, cnt2, bc;
    bit v, e, r, xwe, xcl;
    logic [7:0] d;
    void'($urandom(32'h5eed));
    setup(1'b1, 16'h1000);
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(!buf_we && !wr_en && !busy, "R11 reset outputs", {buf_we, wr_en, busy}, 0);
    @(negedge clk); rst_n = 1; enable = 1;
    put(0, 0, 0, 0);
    // random phase, continuous descriptors
    m_idx = 0; m_cnt = 0;
    for (int k = 0; k < 3000; k++) begin
      v = ($urandom % 4) != 0; d = 8'($urandom);
      e = ($urandom % 8) == 0; r = ($urandom % 32) == 0;
      put(v, d, e, r);
      xwe = v && !r;
      cnt2 = m_cnt + (xwe ? 1 : 0);
      xcl = v && (r || e || cnt2 == MB);
      chk(buf_we == xwe, "R2 store strobe", buf_we, xwe);
      if (xwe && buf_we)
        chk(buf_addr == rptr[m_idx] + AW'(m_cnt) && buf_data == d, "R1 R2 address",
            buf_addr, rptr[m_idx] + AW'(m_cnt));
      chk(wr_en == xcl, "R3 R4 close", wr_en, xcl);
      if (xcl && wr_en) begin
        chk(wr_idx == 2'(m_idx), "R5 next index", wr_idx, m_idx);
        chk(wr_data == mk(1'b1, rwrap[m_idx], 1'b1, e, r, cnt2, rptr[m_idx]),
            "R3 R4 R6 write-back", wr_data, mk(1'b1, rwrap[m_idx], 1'b1, e, r, cnt2, rptr[m_idx]));
      end
      chk(!busy, "R7 no busy when free", busy, 0);
      m_cnt = cnt2;
      if (xcl) begin m_cnt = 0; m_idx = rwrap[m_idx] ? 0 : (m_idx + 1) % ND; end
    end
    // R10 disable mid-buffer, bytes ignored
    put(1, 8'h11, 0, 0);
    enable = 0;
    for (int k = 0; k < 4; k++) begin
      put(1, 8'h22, k == 2, k == 3);
      chk(!buf_we && !wr_en && !busy, "R10 disabled quiet", {buf_we, wr_en, busy}, 0);
    end
    setup(1'b0, 16'h2000);
    enable = 1;
    put(0, 0, 0, 0);
    // single-byte frames to 0,1,2 then wrap to 0
    for (int i = 0; i < 3; i++) begin
      put(1, 8'(i + 5), 1, 0);
      chk(buf_we && buf_addr == rptr[i], "R10 R1 restart address", buf_addr, rptr[i]);
      chk(wr_en && wr_idx == 2'(i) && wr_data == mk(0, rwrap[i], 0, 1, 0, 1, rptr[i]),
          "R6 empty cleared", wr_data, mk(0, rwrap[i], 0, 1, 0, 1, rptr[i]));
    end
    put(1, 8'h77, 0, 0);
    chk(busy && !buf_we && !wr_en, "R7 busy on used descriptor", {busy, buf_we, wr_en}, 3'b100);
    bc = 0;
    for (int k = 0; k < 3 * RF; k++) begin
      put(k == 0, 8'h78, 0, 0);
      if (k == 0) chk(!busy, "R8 silent drop", busy, 0);
      chk(!buf_we && !wr_en, "R8 no write while stalled", {buf_we, wr_en}, 0);
      bc += busy;
    end
    chk(bc == 3, "R8 busy recurs per refresh", bc, 3);
    @(negedge clk);
    for (int i = 0; i < 3; i++) ram[i][DW-1] = 1'b1;
    bc = 0;
    for (int k = 0; k < RF + 1; k++) begin put(0, 0, 0, 0); bc += busy; end
    chk(bc == 0, "R9 no busy after free", bc, 0);
    put(1, 8'h99, 1, 0);
    chk(buf_we && buf_addr == rptr[0] && wr_en && wr_idx == 0, "R9 resume same descriptor",
        buf_addr, rptr[0]);
    // R4 error close on descriptor 1
    put(1, 8'hA0, 0, 0);
    chk(buf_we && buf_addr == rptr[1], "R4 first byte", buf_addr, rptr[1]);
    put(1, 8'hA1, 0, 0);
    chk(buf_we && buf_addr == rptr[1] + 1, "R4 second byte", buf_addr, rptr[1] + 1);
    put(1, 8'hA2, 0, 1);
    chk(!buf_we, "R4 errored byte not stored", buf_we, 0);
    chk(wr_en && wr_data == mk(0, 0, 0, 0, 1, 2, rptr[1]), "R4 error write-back",
        wr_data, mk(0, 0, 0, 0, 1, 2, rptr[1]));
    // R3 full buffer on descriptor 2
    for (int k = 0; k < MB; k++) begin
      put(1, 8'(k), 0, 0);
      chk(wr_en == (k == MB - 1), "R3 close at capacity", wr_en, k == MB - 1);
    end
    chk(wr_data == mk(0, 1, 0, 0, 0, MB, rptr[2]), "R3 full write-back",
        wr_data, mk(0, 1, 0, 0, 0, MB, rptr[2]));
    // R5 wrap from 2 goes to 0, which is now in use
    put(1, 8'h55, 1, 0);
    chk(busy && !buf_we, "R5 wrapped to used descriptor 0", busy, 1);
    put(0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule